// File: doc/BRIEF.md
# CCD Pixel Readout Timing Sequencer

This block generates the timing lines for reading a CCD through a dual-slope integrating front end. A host fills a small program memory through a plain write port. Each program word is either a pattern command or a loop command. A pattern command drives a 12-bit output pattern for a set number of 20 ns ticks, which matches the 50 MHz timing clock. A loop command jumps back to an earlier address a given number of times. A typical pixel subprogram drives, in this order: sensor reset, integrator reset, the down-ramp (noise) window, an isolation gap, the up-ramp (signal) window and the ADC sample-and-hold strobe. It then clocks the serial register. A loop around the subprogram repeats it once for each pixel of a row. A parallel-transfer step ends the program.

The two integration windows can take their length from a run-time window select instead of a fixed count. This lets one program serve three integration times: 25, 50 or 75 ticks. A start pulse runs the program from address 0. At the command that carries the end flag, the block stops, returns all lines low and pulses a done flag. The outputs are single-ended logic levels, and differential drivers sit outside the block.

Top module: `ccd_timing_seq`

## Requirements
- R1: While reset is held and after it is released, every timing output and `done` are low.
- R2: A pattern command (bit 31 = 0) drives its pattern field, bits 27:16, onto the outputs for exactly N consecutive cycles. N is its tick field, bits 15:0. When the next command is also a pattern command, it follows with no gap.
- R3: A pattern command with a tick count of zero lasts exactly one cycle.
- R4: When bit 29 of a pattern command is set, its duration comes from `winSel` and its tick field is ignored. A `winSel` of 0 gives 25 cycles, 1 gives 50 cycles, and 2 or 3 gives 75 cycles.
- R5: A loop command (bit 31 = 1) holds the previous outputs for one cycle. Its target address is in bits 20:16 and its count C in bits 15:0. On the first C visits it jumps to the target, and on the next visit it falls through to the following address. With C = 0 it always falls through.
- R6: After a pattern command with bit 30 set has run its duration, all outputs go low and `done` is high for exactly one cycle. The sequencer then stays idle until the next start.
- R7: A start sampled while idle begins execution at address 0. The first pattern appears on the second clock edge after that start, and the outputs are low in between. A start sampled while running has no effect.
- R8: A program-memory write presented while the sequencer is running is discarded.
- R9: Pattern bits 5:0 drive `pixPhase`: bit 0 sensor reset, 1 integrator reset, 2 down-ramp, 3 isolation, 4 up-ramp, 5 ADC sample. Bits 8:6 drive `parClk` and bits 11:9 drive `serClk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run the program from address 0 |
| winSel | input | 2 | Integration window select for window-flagged commands |
| progWe | input | 1 | Program memory write strobe |
| progAddr | input | ADDR_W (5) | Program memory write address |
| progData | input | 32 | Program word to write |
| pixPhase | output | 6 | Pixel phase lines (reset, integrate, sample) |
| parClk | output | 3 | Parallel-transfer clock lines |
| serClk | output | 3 | Serial-register and reset clock lines |
| done | output | 1 | One-cycle pulse at program end |

## Verification
The outputs are low in the cycle after a start is sampled. The first pattern shows after the second edge. Each pattern then holds for its tick count, and every loop command adds one cycle that repeats the previous pattern. `done` rises on the edge that ends the last pattern. The bench builds the full expected per-cycle trace from the stored program before each run. It samples on every falling edge from the cycle after start up to and including the done cycle, then one further cycle to confirm that the sequencer is idle. Writes and starts injected during a run are judged by the rest of that trace and by a second run of the same program.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W  = 32;
  localparam int PAT_W   = 12;
  localparam int CNT_W   = 16;
  localparam int PIX_W   = 6;
  localparam int PAR_W   = 3;
  localparam int SER_W   = 3;
  localparam int PAT_LSB = 16;
  localparam int TGT_LSB = 16;
  localparam int F_WIN   = 29;
  localparam int F_END   = 30;
  localparam int F_LOOP  = 31;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_ZERO,
    PC_ADDR,
    PC_STEP,
    PC_JUMP
  } pcSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HOLD
  } seqState_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   loadPat;
    logic   decTick;
    logic   loopLoad;
    logic   loopDec;
    logic   loopClr;
    logic   clearOut;
  } seqCtl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WIN_UNIT = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic                 rdNext,
  input  logic                 running,
  input  logic [1:0]           winSel,
  input  logic                 progWe,
  input  logic [ADDR_W-1:0]    progAddr,
  input  logic [WORD_W-1:0]    progData,
  output logic                 wordIsLoop,
  output logic                 wordCntZero,
  output logic                 tickZero,
  output logic                 loopActive,
  output logic                 loopCntZero,
  output logic                 curEnd,
  output logic [PAT_W-1:0]     patOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] WIN_ONE   = CNT_W'(WIN_UNIT);
  localparam logic [CNT_W-1:0] WIN_TWO   = CNT_W'(2 * WIN_UNIT);
  localparam logic [CNT_W-1:0] WIN_THREE = CNT_W'(3 * WIN_UNIT);

  logic [WORD_W-1:0] progMem [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  tick;
  logic [CNT_W-1:0]  loopCnt;
  logic [CNT_W-1:0]  winTicks;
  logic [CNT_W-1:0]  durTicks;
  logic [CNT_W-1:0]  tickInit;
  logic [PAT_W-1:0]  patReg;

  // program store: host writes land only while idle
  always_ff @(posedge clk) begin
    if (progWe && !running) progMem[progAddr] <= progData;
  end

  assign rdAddr = rdNext ? pc + ADDR_W'(1) : pc;
  assign word   = progMem[rdAddr];

  assign wordIsLoop  = word[F_LOOP];
  assign wordCntZero = (word[CNT_W-1:0] == '0);

  always_comb begin
    case (winSel)
      2'd0:    winTicks = WIN_ONE;
      2'd1:    winTicks = WIN_TWO;
      default: winTicks = WIN_THREE;
    endcase
  end

  assign durTicks = word[F_WIN] ? winTicks : word[CNT_W-1:0];
  assign tickInit = (durTicks == '0) ? '0 : durTicks - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else begin
      case (ctl.pcSel)
        PC_ZERO: pc <= '0;
        PC_ADDR: pc <= rdAddr;
        PC_STEP: pc <= rdAddr + ADDR_W'(1);
        PC_JUMP: pc <= word[TGT_LSB +: ADDR_W];
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick   <= '0;
      patReg <= '0;
      curEnd <= 1'b0;
    end else begin
      if (ctl.loadPat) begin
        tick   <= tickInit;
        patReg <= word[PAT_LSB +: PAT_W];
        curEnd <= word[F_END];
      end else begin
        if (ctl.decTick) tick <= tick - CNT_W'(1);
        if (ctl.clearOut) begin
          patReg <= '0;
          curEnd <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopCnt    <= '0;
      loopActive <= 1'b0;
    end else if (ctl.loopLoad) begin
      loopCnt    <= word[CNT_W-1:0] - CNT_W'(1);
      loopActive <= 1'b1;
    end else if (ctl.loopDec) begin
      loopCnt    <= loopCnt - CNT_W'(1);
    end else if (ctl.loopClr) begin
      loopCnt    <= '0;
      loopActive <= 1'b0;
    end
  end

  assign tickZero    = (tick == '0);
  assign loopCntZero = (loopCnt == '0);
  assign patOut      = patReg;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decTick |=> $stable(patReg)); // R2

  AST_ZERO_DUR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadPat && durTicks == '0) |=> tickZero); // R3

  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearOut |=> (patReg == '0)); // R6

  AST_LOOP_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (loopActive && !ctl.loopLoad) |=> (loopCnt <= $past(loopCnt))); // R5

  AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (progWe && running) |=> (progMem[$past(progAddr)] == $past(progMem[progAddr]))); // R8
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    wordIsLoop,
  input  logic    wordCntZero,
  input  logic    tickZero,
  input  logic    loopActive,
  input  logic    loopCntZero,
  input  logic    curEnd,
  output seqCtl_t ctl,
  output logic    rdNext,
  output logic    running,
  output logic    done
);
  seqState_e state;
  seqState_e nextState;
  logic      issue;
  logic      doneNext;

  assign rdNext  = (state == ST_HOLD);
  assign running = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    ctl.pcSel = PC_HOLD;
    nextState = state;
    issue     = 1'b0;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.pcSel = PC_ZERO;
          nextState = ST_FETCH;
        end
      end
      ST_FETCH: issue = 1'b1;
      ST_HOLD: begin
        if (!tickZero) begin
          ctl.decTick = 1'b1;
        end else if (curEnd) begin
          ctl.clearOut = 1'b1;
          doneNext     = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          issue = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase

    if (issue) begin
      if (!wordIsLoop) begin
        ctl.loadPat = 1'b1;
        ctl.pcSel   = PC_ADDR;
        nextState   = ST_HOLD;
      end else begin
        nextState = ST_FETCH;
        if (!loopActive) begin
          if (wordCntZero) begin
            ctl.pcSel = PC_STEP;
          end else begin
            ctl.loopLoad = 1'b1;
            ctl.pcSel    = PC_JUMP;
          end
        end else if (loopCntZero) begin
          ctl.loopClr = 1'b1;
          ctl.pcSel   = PC_STEP;
        end else begin
          ctl.loopDec = 1'b1;
          ctl.pcSel   = PC_JUMP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNext;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> (state == ST_FETCH)); // R7

  AST_BUSY_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !(state == ST_HOLD && tickZero && curEnd)) |=> (state != ST_IDLE)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE)); // R6
endmodule

// File: rtl/ccd_timing_seq.sv
module ccd_timing_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WIN_UNIT = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        winSel,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [31:0]       progData,
  output logic [5:0]        pixPhase,
  output logic [2:0]        parClk,
  output logic [2:0]        serClk,
  output logic              done
);
  seqCtl_t          ctl;
  logic             rdNext;
  logic             running;
  logic             wordIsLoop;
  logic             wordCntZero;
  logic             tickZero;
  logic             loopActive;
  logic             loopCntZero;
  logic             curEnd;
  logic [PAT_W-1:0] patOut;

  seq_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .wordIsLoop  (wordIsLoop),
    .wordCntZero (wordCntZero),
    .tickZero    (tickZero),
    .loopActive  (loopActive),
    .loopCntZero (loopCntZero),
    .curEnd      (curEnd),
    .ctl         (ctl),
    .rdNext      (rdNext),
    .running     (running),
    .done        (done)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .WIN_UNIT(WIN_UNIT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .rdNext      (rdNext),
    .running     (running),
    .winSel      (winSel),
    .progWe      (progWe),
    .progAddr    (progAddr),
    .progData    (progData),
    .wordIsLoop  (wordIsLoop),
    .wordCntZero (wordCntZero),
    .tickZero    (tickZero),
    .loopActive  (loopActive),
    .loopCntZero (loopCntZero),
    .curEnd      (curEnd),
    .patOut      (patOut)
  );

  // pattern field split into the three line groups (R9)
  assign pixPhase = patOut[PIX_W-1:0];
  assign parClk   = patOut[PIX_W +: PAR_W];
  assign serClk   = patOut[PIX_W+PAR_W +: SER_W];
endmodule

// File: tb/sim_ccd_timing_seq.sv
module sim_ccd_timing_seq;
  localparam int ADDR_W   = 5;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int WIN_UNIT = 25;
  localparam int MAXLEN   = 4096;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        winSel = 2'd0;
  logic              progWe = 1'b0;
  logic [ADDR_W-1:0] progAddr = '0;
  logic [31:0]       progData = '0;
  logic [5:0]        pixPhase;
  logic [2:0]        parClk;
  logic [2:0]        serClk;
  logic              done;

  ccd_timing_seq #(.ADDR_W(ADDR_W), .WIN_UNIT(WIN_UNIT)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .winSel(winSel),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .pixPhase(pixPhase), .parClk(parClk), .serClk(serClk), .done(done)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [DEPTH];
  logic [11:0] expv [MAXLEN];
  int expLen;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] mkPat(bit e, bit w, logic [11:0] p, logic [15:0] d);
    return {1'b0, e, w, 1'b0, p, d};
  endfunction

  function automatic logic [31:0] mkLoop(int tgt, logic [15:0] c);
    logic [4:0] t;
    t = tgt[4:0];
    return {1'b1, 10'b0, t, c};
  endfunction

  function automatic logic [11:0] outNow();
    return {serClk, parClk, pixPhase};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // expected per-cycle trace, from the cycle after start to the last pattern cycle
  task automatic buildExp(int win);
    int pc = 0;
    bit act = 0;
    int rem = 0;
    logic [11:0] prev = '0;
    bit fin = 0;
    expLen = 0;
    expv[expLen++] = '0;
    while (!fin && expLen < MAXLEN - 100) begin
      logic [31:0] w = prog[pc];
      if (w[31]) begin
        expv[expLen++] = prev;
        if (!act) begin
          if (w[15:0] == 0) pc = (pc + 1) % DEPTH;
          else begin act = 1; rem = int'(w[15:0]) - 1; pc = int'(w[20:16]); end
        end else if (rem == 0) begin
          act = 0; pc = (pc + 1) % DEPTH;
        end else begin
          rem--; pc = int'(w[20:16]);
        end
      end else begin
        int d = w[29] ? WIN_UNIT * ((win == 0) ? 1 : (win == 1) ? 2 : 3) : int'(w[15:0]);
        if (d == 0) d = 1;
        for (int k = 0; k < d; k++) expv[expLen++] = w[27:16];
        prev = w[27:16];
        if (w[30]) fin = 1;
        pc = (pc + 1) % DEPTH;
      end
    end
  endtask

  task automatic loadProg();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      progWe = 1'b1; progAddr = ADDR_W'(a); progData = prog[a];
    end
    @(negedge clk);
    progWe = 1'b0;
  endtask

  // run and compare; midStart / midWr give a sample index for an injected start / write (-1 none)
  task automatic runProg(string tag, int win, int midStart, int midWr);
    int badAt = -1;
    logic [11:0] badGot = '0;
    int doneBad = -1;
    winSel = 2'(win);
    buildExp(win);
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i <= expLen; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (i < expLen) begin
        if (outNow() !== expv[i] && badAt < 0) begin badAt = i; badGot = outNow(); end
      end else if (outNow() !== 12'h000 && badAt < 0) begin
        badAt = i; badGot = outNow();
      end
      if (done !== (i == expLen) && doneBad < 0) doneBad = i;
      progWe = 1'b0;
      if (i == midStart) start = 1'b1;
      else if (i == midStart + 1) start = 1'b0;
      if (i == midWr) begin
        progWe = 1'b1; progAddr = '0; progData = mkPat(1'b1, 1'b0, 12'hABC, 16'd7);
      end
    end
    start = 1'b0;
    progWe = 1'b0;
    checks++;
    if (badAt >= 0) begin
      errors++;
      $display("FAIL %s trace cycle %0d got %h expected %h", tag, badAt, badGot,
               (badAt < expLen) ? expv[badAt] : 12'h000);
    end
    checks++;
    if (doneBad >= 0) begin
      errors++;
      $display("FAIL R6 %s done at cycle %0d got %b expected %b", tag, doneBad,
               ~(doneBad == expLen), (doneBad == expLen));
    end
    @(negedge clk);
    check({tag, " R6 idle after done"}, {19'd0, done, outNow()}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EC0_0017));
    for (int a = 0; a < DEPTH; a++) prog[a] = mkPat(1'b1, 1'b0, 12'h000, 16'd1);
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {19'd0, done, outNow()}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs after reset", {19'd0, done, outNow()}, 32'd0);

    // dual-slope pixel program, three pixels, then a parallel transfer (R2 R4 R5 R9)
    prog[0] = mkPat(1'b0, 1'b0, 12'h001, 16'd3);
    prog[1] = mkPat(1'b0, 1'b0, 12'h002, 16'd2);
    prog[2] = mkPat(1'b0, 1'b1, 12'h004, 16'd9);
    prog[3] = mkPat(1'b0, 1'b0, 12'h008, 16'd4);
    prog[4] = mkPat(1'b0, 1'b1, 12'h010, 16'd9);
    prog[5] = mkPat(1'b0, 1'b0, 12'h020, 16'd2);
    prog[6] = mkPat(1'b0, 1'b0, 12'h200, 16'd1);
    prog[7] = mkLoop(0, 16'd2);
    prog[8] = mkPat(1'b1, 1'b0, 12'h1C0, 16'd5);
    loadProg();
    runProg("R2 R5 R9 pixel loop", 0, -1, -1);
    for (int s = 1; s < 4; s++) runProg("R4 window select", s, -1, -1);

    // zero durations (R3) and loop count zero (R5)
    prog[0] = mkPat(1'b0, 1'b0, 12'h5A5, 16'd0);
    prog[1] = mkPat(1'b0, 1'b0, 12'hA5A, 16'd0);
    prog[2] = mkLoop(0, 16'd0);
    prog[3] = mkPat(1'b0, 1'b0, 12'h0F0, 16'd1);
    prog[4] = mkPat(1'b1, 1'b0, 12'hF0F, 16'd0);
    loadProg();
    runProg("R3 R5 zero ticks and zero loop", 0, -1, -1);

    // start while running ignored (R7), write while running ignored (R8)
    prog[0] = mkPat(1'b0, 1'b0, 12'h011, 16'd6);
    prog[1] = mkPat(1'b0, 1'b0, 12'h222, 16'd6);
    prog[2] = mkLoop(0, 16'd1);
    prog[3] = mkPat(1'b1, 1'b0, 12'h444, 16'd3);
    loadProg();
    runProg("R7 start during run", 0, 5, -1);
    runProg("R8 write during run", 0, -1, 4);
    runProg("R8 rerun after blocked write", 0, -1, -1);

    // random programs
    for (int r = 0; r < 14; r++) begin
      int n = 2 + int'($urandom % 5);
      for (int k = 0; k < n; k++)
        prog[k] = mkPat(1'b0, ($urandom % 5) == 0, 12'($urandom), 16'($urandom % 5));
      prog[n]     = mkLoop(int'($urandom % n), 16'($urandom % 4));
      prog[n + 1] = mkPat(1'b1, 1'b0, 12'($urandom), 16'($urandom % 4));
      loadProg();
      runProg("R2 R5 random program", int'($urandom % 4), -1, -1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule